// File: doc/BRIEF.md
# Synchronous Dual-Ratio Clock Divider

This block turns one input clock into two divided clocks. Output A runs at one half or one quarter of the input rate, and output B runs at one quarter or one sixth. A shared modulo-12 phase counter drives both outputs, and both output flops are clocked by the same rising input edge. Any rising edges that the two outputs have in common therefore fall on the same input edge. No reset is needed to keep the two outputs of one instance in step with each other.

An active-low run input starts and stops the dividers. A flop clocked on the falling input edge captures it, so an output can only freeze or resume between pulses and never produces a shortened pulse. An active-high asynchronous master reset clears every output and every internal state. Releasing the same reset on several instances puts them in lockstep.

The ratio selects are sampled on rising edges. A new ratio is loaded only when the shared phase counter leaves phase 0. In phase 0 every output is low and every ratio has just finished a whole period.

Top module: `dual_ratio_divider`

## Requirements
- R1: With `sel_a` = 0, `clk_a` is the input clock divided by 2. With `sel_a` = 1 it is divided by 4, high for 2 and low for 2 enabled input cycles.
- R2: With `sel_b` = 0, `clk_b` is the input clock divided by 4 (2 high, 2 low). With `sel_b` = 1 it is divided by 6, high for 3 and low for 3 enabled input cycles.
- R3: While `run_n` is high, both outputs hold their levels. While it is low, they divide. `run_n` is captured on the falling input edge, so a change first affects the next rising edge after that falling edge.
- R4: While `mreset` is high, both outputs are low at once, without waiting for a clock edge, whatever the states of `run_n` and the selects.
- R5: Both outputs change only on rising input edges. Whenever `clk_b` rises, `clk_a` rises on the same edge, unless A divides by 4 while B divides by 6. In that combination the two outputs rise together once every 12 enabled edges.
- R6: After reset is released, the first rising edges of both outputs fall on the first enabled rising input edge.
- R7: A change of `sel_a` or `sel_b` takes effect only at the edge that leaves phase 0 of the 12-edge cycle. Until then the old ratio continues, and no pulse is shortened.
- R8: With every control input held low, the block runs with A divided by 2 and B divided by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| mreset | input | 1 | Asynchronous master reset, active high |
| run_n | input | 1 | Divide enable, active low, captured on the falling edge |
| sel_a | input | 1 | Ratio select for A: 0 divides by 2, 1 divides by 4 |
| sel_b | input | 1 | Ratio select for B: 0 divides by 4, 1 divides by 6 |
| clk_a | output | 1 | Divided clock A |
| clk_b | output | 1 | Divided clock B |

## Verification
The assertions check on every cycle that:
- the outputs stay frozen while the captured enable is off;
- a rise of B comes with a rise of A in the ratio pairs where that must hold;
- a ratio switch happens only while both outputs are low;
- the outputs are low during reset;
- the phase counter stays in range.

The exact ratios and duty cycles can only be shown by the bench scenarios, which compare every sampled output level against an arithmetic count of enabled edges. The same applies to the one-edge latency of the falling-edge enable, to a select change made part-way through a period, and to the first edges after reset.

// File: rtl/dual_div_pkg.sv
package dual_div_pkg;
    localparam int PHASE_MOD = 12;
    localparam int PH_W      = $clog2(PHASE_MOD);

    typedef logic [PH_W-1:0] phase_t;

    typedef struct packed {
        phase_t phase;
        logic   sel_a;
        logic   sel_b;
    } ctr_state_t;

    typedef struct packed {
        logic wave_a;
        logic wave_b;
    } wave_t;
endpackage

// File: rtl/dd_run_gate.sv
module dd_run_gate (
    input  logic clk_in,
    input  logic mreset,
    input  logic run_n,
    output logic run_q
);
    logic run_d;

    always_comb begin
        run_d = ~run_n;
    end

    always_ff @(negedge clk_in or posedge mreset) begin
        if (mreset) run_q <= 1'b0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/dd_phase_ctr.sv
module dd_phase_ctr
    import dual_div_pkg::*;
(
    input  logic       clk_in,
    input  logic       mreset,
    input  logic       adv,
    input  logic       sel_a,
    input  logic       sel_b,
    output ctr_state_t st_d,
    output ctr_state_t st_q
);
    localparam phase_t LAST = phase_t'(PHASE_MOD - 1);

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.phase == '0) begin
                st_d.sel_a = sel_a;
                st_d.sel_b = sel_b;
            end
            st_d.phase = (st_q.phase == LAST) ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_in or posedge mreset) begin
        if (mreset) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PHASE_RANGE: assert property (@(posedge clk_in) disable iff (mreset)
        st_q.phase <= LAST); // R5
endmodule

// File: rtl/dd_wave_decode.sv
module dd_wave_decode
    import dual_div_pkg::*;
#(
    parameter int DIV_A_LO = 2,
    parameter int DIV_A_HI = 4,
    parameter int DIV_B_LO = 4,
    parameter int DIV_B_HI = 6
) (
    input  logic       clk_in,
    input  logic       mreset,
    input  ctr_state_t st_d,
    output wave_t      wave_q
);
    wave_t wave_d;

    function automatic logic level_at(input phase_t p, input int n);
        int r;
        r = int'(p) % n;
        return (r >= 1) && (r <= n / 2);
    endfunction

    always_comb begin
        wave_d.wave_a = level_at(st_d.phase, st_d.sel_a ? DIV_A_HI : DIV_A_LO);
        wave_d.wave_b = level_at(st_d.phase, st_d.sel_b ? DIV_B_HI : DIV_B_LO);
    end

    always_ff @(posedge clk_in or posedge mreset) begin
        if (mreset) wave_q <= '0;
        else        wave_q <= wave_d;
    end
endmodule

// File: rtl/dual_ratio_divider.sv
module dual_ratio_divider
    import dual_div_pkg::*;
#(
    parameter int DIV_A_LO = 2,
    parameter int DIV_A_HI = 4,
    parameter int DIV_B_LO = 4,
    parameter int DIV_B_HI = 6
) (
    input  logic clk_in,
    input  logic mreset,
    input  logic run_n,
    input  logic sel_a,
    input  logic sel_b,
    output logic clk_a,
    output logic clk_b
);
    logic       run_q;
    ctr_state_t st_d;
    ctr_state_t st_q;
    wave_t      wave_q;

    dd_run_gate gate_i (
        .clk_in (clk_in),
        .mreset (mreset),
        .run_n  (run_n),
        .run_q  (run_q)
    );

    dd_phase_ctr ctr_i (
        .clk_in (clk_in),
        .mreset (mreset),
        .adv    (run_q),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .st_d   (st_d),
        .st_q   (st_q)
    );

    dd_wave_decode #(
        .DIV_A_LO (DIV_A_LO),
        .DIV_A_HI (DIV_A_HI),
        .DIV_B_LO (DIV_B_LO),
        .DIV_B_HI (DIV_B_HI)
    ) dec_i (
        .clk_in (clk_in),
        .mreset (mreset),
        .st_d   (st_d),
        .wave_q (wave_q)
    );

    assign clk_a = wave_q.wave_a;
    assign clk_b = wave_q.wave_b;

    AST_HOLD_FROZEN: assert property (@(posedge clk_in) disable iff (mreset)
        !run_q |=> ($stable(clk_a) && $stable(clk_b))); // R3

    AST_RESET_LOW: assert property (@(posedge clk_in)
        mreset |-> (!clk_a && !clk_b)); // R4

    AST_COMMON_RISE: assert property (@(posedge clk_in) disable iff (mreset)
        ($rose(clk_b) && !(st_q.sel_a && st_q.sel_b)) |-> $rose(clk_a)); // R5

    AST_SWITCH_WHEN_LOW: assert property (@(posedge clk_in) disable iff (mreset)
        (!$stable(st_q.sel_a) || !$stable(st_q.sel_b)) |-> ($past(clk_a) == 1'b0 && $past(clk_b) == 1'b0)); // R7
endmodule

// File: tb/dual_ratio_divider_tb_top.sv
module dual_ratio_divider_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MOD = 12;

    logic clk_in = 1'b0;
    logic mreset = 1'b1;
    logic run_n = 1'b0;
    logic sel_a = 1'b0;
    logic sel_b = 1'b0;
    logic clk_a, clk_b;

    int n_chk = 0;
    int n_bad = 0;

    int m_ph = 0;
    logic m_gate = 1'b0;
    logic m_sa = 1'b0;
    logic m_sb = 1'b0;

    always #(CLK_PERIOD/2) clk_in = ~clk_in;

    dual_ratio_divider dut_i (
        .clk_in (clk_in), .mreset (mreset), .run_n (run_n),
        .sel_a (sel_a), .sel_b (sel_b), .clk_a (clk_a), .clk_b (clk_b)
    );

    function automatic logic lvl(input int p, input int n);
        return ((p % n) >= 1) && ((p % n) <= n / 2);
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string ta, input string tb);
        @(negedge clk_in);
        m_gate = mreset ? 1'b0 : ~run_n;
        @(posedge clk_in);
        if (!mreset && m_gate) begin
            if (m_ph == 0) begin
                m_sa = sel_a;
                m_sb = sel_b;
            end
            m_ph = (m_ph + 1) % MOD;
        end
        #1;
        chk(ta, clk_a, lvl(m_ph, m_sa ? 4 : 2));
        chk(tb, clk_b, lvl(m_ph, m_sb ? 6 : 4));
    endtask

    task automatic do_reset();
        mreset = 1'b1;
        m_ph = 0; m_gate = 1'b0; m_sa = 1'b0; m_sb = 1'b0;
        #1;
        chk("R4 reset a", clk_a, 1'b0);
        chk("R4 reset b", clk_b, 1'b0);
        step("R4", "R4");
        step("R4", "R4");
        mreset = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(posedge clk_in); #1;
        // R8: defaults, all controls low
        do_reset();
        for (int i = 0; i < 30; i++) step("R8 R1", "R8 R2");

        // R1 R2 R6: every select pair after a fresh reset
        for (int c = 0; c < 4; c++) begin
            sel_a = c[0]; sel_b = c[1];
            do_reset();
            step("R6 first a", "R6 first b");
            chk("R6 a high", clk_a, 1'b1);
            chk("R6 b high", clk_b, 1'b1);
            for (int i = 0; i < 40; i++) step("R1", "R2 R5");
        end

        // R3: freeze mid period, then resume
        sel_a = 1'b1; sel_b = 1'b1;
        do_reset();
        for (int i = 0; i < 7; i++) step("R1", "R2");
        run_n = 1'b1;
        for (int i = 0; i < 6; i++) step("R3 hold a", "R3 hold b");
        chk("R3 frozen phase b", clk_b, lvl(7, 6));
        run_n = 1'b0;
        for (int i = 0; i < 20; i++) step("R3 resume a", "R3 resume b");
        // short pulse on run_n
        for (int k = 0; k < 5; k++) begin
            run_n = 1'b1; step("R3", "R3");
            run_n = 1'b0; step("R3", "R3");
        end

        // R7: select changes mid period
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 5 + k; i++) step("R7", "R7");
            sel_a = ~sel_a;
            if (k[0]) sel_b = ~sel_b;
            for (int i = 0; i < 26; i++) step("R7 a", "R7 b");
        end

        // R4: reset while outputs high, with run_n high too
        sel_a = 1'b0; sel_b = 1'b0; run_n = 1'b0;
        do_reset();
        step("R1", "R2");
        chk("R4 pre a", clk_a, 1'b1);
        run_n = 1'b1;
        do_reset();
        run_n = 1'b0;
        for (int i = 0; i < 12; i++) step("R4 recovery", "R4 recovery");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule